// File: doc/BRIEF.md
# Image Readout Timing Generator

This block sequences the readout of a pixel array and produces the line and frame sync signals that go with the pixel stream. A clock-enable divider derives the data-clock rate from the master clock. On each data-clock tick the block advances a position counter within the line and a line counter within the frame. From these it drives the row and column address of the pixel to fetch, a pixel-valid strobe, and programmable horizontal and vertical syncs.

The readout window is given by a start row and column, a depth and a width. It can be thinned in Bayer space by keeping one 2-pixel (or 2-row) pair and then skipping 0 to 3 pairs. It can be traversed in reverse order in either direction. The window's column start always lands on an even column. Blanking depths set the line and frame period. A line-hold input lets a downstream consumer stall the start of the next row. All frame geometry is captured once per frame, so the programming interface can write fields at any time without tearing a frame.

Top module: `img_readout_timer`

## Requirements
- R1: `div_sel` codes 0, 1, 2 and 3 make `dclk_en` pulse once every 1, 2, 4 and 8 master clocks.
- R2: A line lasts K + `hblank` ticks, where K is the number of kept columns of the window. A frame lasts N + `vblank` lines, where N is the number of kept rows.
- R3: Bit 0 of `win_col0` is ignored. Column addresses start from `win_col0` with its LSB cleared.
- R4: Within a line, the first kept pixel is output at tick 42 after the line start. Within a frame, the first kept row is line 2. With a sync start of 0, the line start is the leading edge of the horizontal sync pulse.
- R5: In sync mode (mode bit 0), a sync is asserted from position `*_start` for `*_width` units: ticks for the horizontal sync, lines for the vertical sync. A polarity bit of 0 means active high and 1 means active low.
- R6: In data-valid mode (mode bit 1), `hsync` is asserted exactly while kept pixels of a kept row are output, and `vsync` is asserted for every line of the kept-row span.
- R7: Subsample code s (0 to 3) keeps 2 consecutive columns (rows) and then skips 2*s. Kept offsets within the window are those with offset mod 2(s+1) below 2.
- R8: With `mirror_h` at 1, columns are read from window end to window start, so address = column start + width - 1 - offset. With `mirror_v` at 1, rows are read the same reversed way.
- R9: While `hold_n` is 0 at the last tick of a line, the line end is repeated and the next line does not start. It starts on the first tick after `hold_n` returns to 1.
- R10: All window, blank and sync fields are captured at frame start. A change made mid-frame takes effect from the next frame.
- R11: `pix_valid` is 1 only for kept pixels of kept rows, in the same tick as their addresses. Both addresses read 0 whenever `pix_valid` is 0.
- R12: During reset and on the first tick after it, `pix_valid`, `hsync`, `vsync` and both addresses are 0. The frame then starts at line 0, position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Data-clock divide code |
| win_row0 | input | 9 | Window start row |
| win_col0 | input | 10 | Window start column (LSB ignored) |
| win_rows | input | 9 | Window depth in rows |
| win_cols | input | 10 | Window width in columns |
| sub_row | input | 2 | Row subsample code |
| sub_col | input | 2 | Column subsample code |
| mirror_h | input | 1 | Reverse column order |
| mirror_v | input | 1 | Reverse row order |
| hblank | input | 14 | Horizontal blank depth in ticks |
| vblank | input | 12 | Vertical blank depth in lines |
| hs_width | input | 8 | Horizontal sync width in ticks |
| vs_width | input | 8 | Vertical sync width in lines |
| hs_start | input | 10 | Horizontal sync start position |
| vs_start | input | 10 | Vertical sync start line |
| hs_pol | input | 1 | Horizontal sync polarity (1 = active low) |
| vs_pol | input | 1 | Vertical sync polarity (1 = active low) |
| hs_valid_mode | input | 1 | Horizontal sync as data-valid |
| vs_valid_mode | input | 1 | Vertical sync as row-valid |
| hold_n | input | 1 | Line hold, active low |
| dclk_en | output | 1 | Data-clock enable tick |
| row_addr | output | 9 | Row address being read |
| col_addr | output | 10 | Column address being read |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| pix_valid | output | 1 | Pixel strobe |

## Verification
The bench aims at these corner cases, each with the way a faulty design would show it:
- An odd column start: a design that kept the LSB would start each line on the wrong Bayer phase.
- The 1/3 row rate: a design that used power-of-two thinning would get the kept-row count and the frame length wrong.
- Mirroring combined with 1/4 column thinning: a design that did the reversal wrongly would emit the right addresses in the wrong order or off by one pair.
- Inverted and delayed syncs: these expose pulses placed at the wrong position or with the wrong width.
- Data-valid modes: a design that got them wrong would leak sync assertion into blanking.
- A mid-frame reprogramming: a design that applied new fields at once would tear the current frame.
- A held line end: a design that ignored the hold would start the next row early.

// File: rtl/rd_pkg.sv
package rd_pkg;
  localparam int SPAN_W = 16;
  localparam int ROW_W  = 9;
  localparam int COL_W  = 10;
  localparam int HB_W   = 14;
  localparam int VB_W   = 12;
  localparam int SW_W   = 8;
  localparam int SP_W   = 10;
  localparam int CODE_W = 2;

  typedef logic [SPAN_W-1:0] span_t;

  typedef struct packed {
    logic [ROW_W-1:0]  row0;
    logic [COL_W-1:0]  col0;
    logic [ROW_W-1:0]  rows;
    logic [COL_W-1:0]  cols;
    logic [1:0]        sub_r;
    logic [1:0]        sub_c;
    logic              mir_h;
    logic              mir_v;
    logic [HB_W-1:0]   hblank;
    logic [VB_W-1:0]   vblank;
    logic [SW_W-1:0]   hs_wid;
    logic [SW_W-1:0]   vs_wid;
    logic [SP_W-1:0]   hs_beg;
    logic [SP_W-1:0]   vs_beg;
    logic              hs_pol;
    logic              vs_pol;
    logic              hs_dv;
    logic              vs_dv;
  } frame_cfg_t;

  // Number of samples kept from a span of len when pairs are kept and
  // 'code' pairs skipped after each; constant divisors only.
  function automatic span_t kept_units(input span_t len, input logic [1:0] code);
    span_t q;
    span_t r;
    span_t tail;
    case (code)
      2'd0: begin q = len >> 1; r = len & span_t'(1); end
      2'd1: begin q = len >> 2; r = len & span_t'(3); end
      2'd2: begin q = len / span_t'(6); r = len % span_t'(6); end
      default: begin q = len >> 3; r = len & span_t'(7); end
    endcase
    tail = (r > span_t'(2)) ? span_t'(2) : r;
    return (q << 1) + tail;
  endfunction

  // Offset within the window of the idx-th kept sample.
  function automatic span_t unit_offset(input span_t idx, input logic [1:0] code);
    span_t pair;
    span_t period;
    pair   = idx >> 1;
    period = span_t'({code, 1'b0}) + span_t'(2);
    return (pair * period) + {{(SPAN_W-1){1'b0}}, idx[0]};
  endfunction
endpackage

// File: rtl/rd_ce_div.sv
module rd_ce_div #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_sel,
  output logic              tick
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    mask  = CNT_W'((32'd1 << div_sel) - 32'd1);
    tick  = (cnt_q & mask) == mask;
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: any divide above 1 never gives two ticks back to back
  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0) |=> (!tick || div_sel != $past(div_sel)));
endmodule

// File: rtl/rd_axis_seq.sv
module rd_axis_seq
  import rd_pkg::*;
#(
  parameter int LEAD = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  clear,
  input  span_t kept,
  input  span_t blank,
  output span_t pos,
  output span_t idx,
  output logic  active,
  output logic  at_end
);
  span_t pos_q, pos_d, last;

  always_comb begin
    last   = kept + blank - span_t'(1);
    at_end = (pos_q == last);
    active = (pos_q >= span_t'(LEAD)) && (pos_q < span_t'(LEAD) + kept);
    idx    = pos_q - span_t'(LEAD);
    pos_d  = pos_q;
    if (clear)     pos_d = '0;
    else if (step) pos_d = at_end ? '0 : pos_q + span_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

  // R2: a step at the last position returns the counter to the span start
  assert_span_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_end) |=> (pos_q == '0));
endmodule

// File: rtl/rd_sync_gen.sv
module rd_sync_gen
  import rd_pkg::*;
(
  input  span_t pos,
  input  span_t start,
  input  span_t width,
  input  logic  dv_mode,
  input  logic  dv_span,
  input  logic  pol,
  input  logic  gate,
  output logic  sync_o
);
  logic in_win;
  logic raw;

  always_comb begin
    in_win = (pos >= start) && ((pos - start) < width);
    raw    = dv_mode ? dv_span : in_win;
    sync_o = (raw & gate) ^ pol;
  end
endmodule

// File: rtl/img_readout_timer.sv
module img_readout_timer
  import rd_pkg::*;
#(
  parameter int H_LEAD = 42,
  parameter int V_LEAD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_sel,
  input  logic [ROW_W-1:0]  win_row0,
  input  logic [COL_W-1:0]  win_col0,
  input  logic [ROW_W-1:0]  win_rows,
  input  logic [COL_W-1:0]  win_cols,
  input  logic [1:0]        sub_row,
  input  logic [1:0]        sub_col,
  input  logic              mirror_h,
  input  logic              mirror_v,
  input  logic [HB_W-1:0]   hblank,
  input  logic [VB_W-1:0]   vblank,
  input  logic [SW_W-1:0]   hs_width,
  input  logic [SW_W-1:0]   vs_width,
  input  logic [SP_W-1:0]   hs_start,
  input  logic [SP_W-1:0]   vs_start,
  input  logic              hs_pol,
  input  logic              vs_pol,
  input  logic              hs_valid_mode,
  input  logic              vs_valid_mode,
  input  logic              hold_n,
  output logic              dclk_en,
  output logic [ROW_W-1:0]  row_addr,
  output logic [COL_W-1:0]  col_addr,
  output logic              hsync,
  output logic              vsync,
  output logic              pix_valid
);
  // reset release aligned to clk
  logic [1:0] rs_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic ce_raw;
  rd_ce_div #(.CODE_W(CODE_W)) u_div (
    .clk(clk), .rst_n(rst_sn), .div_sel(div_sel), .tick(ce_raw)
  );
  assign dclk_en = ce_raw & rst_sn;

  // frame-start capture of geometry
  frame_cfg_t cfg_in, cfg_q;
  logic       load_pend_q, load_pend_d;
  logic       h_step, v_step, f_wrap, load, hold_end;
  span_t      kc, kr;
  span_t      h_pos, h_idx, v_pos, v_idx;
  logic       h_act, h_end, v_act, v_end;

  always_comb begin
    cfg_in.row0   = win_row0;
    cfg_in.col0   = win_col0;
    cfg_in.rows   = win_rows;
    cfg_in.cols   = win_cols;
    cfg_in.sub_r  = sub_row;
    cfg_in.sub_c  = sub_col;
    cfg_in.mir_h  = mirror_h;
    cfg_in.mir_v  = mirror_v;
    cfg_in.hblank = hblank;
    cfg_in.vblank = vblank;
    cfg_in.hs_wid = hs_width;
    cfg_in.vs_wid = vs_width;
    cfg_in.hs_beg = hs_start;
    cfg_in.vs_beg = vs_start;
    cfg_in.hs_pol = hs_pol;
    cfg_in.vs_pol = vs_pol;
    cfg_in.hs_dv  = hs_valid_mode;
    cfg_in.vs_dv  = vs_valid_mode;
  end

  always_comb begin
    kc          = kept_units(span_t'(cfg_q.cols), cfg_q.sub_c);
    kr          = kept_units(span_t'(cfg_q.rows), cfg_q.sub_r);
    hold_end    = h_end & ~hold_n;
    h_step      = dclk_en & ~load_pend_q & ~hold_end;
    v_step      = h_step & h_end;
    f_wrap      = v_step & v_end;
    load        = dclk_en & (load_pend_q | f_wrap);
    load_pend_d = load_pend_q & ~dclk_en;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      load_pend_q <= 1'b1;
      cfg_q       <= '0;
    end else begin
      load_pend_q <= load_pend_d;
      if (load) cfg_q <= cfg_in;
    end
  end

  rd_axis_seq #(.LEAD(H_LEAD)) u_hseq (
    .clk(clk), .rst_n(rst_sn), .step(h_step), .clear(load),
    .kept(kc), .blank(span_t'(cfg_q.hblank)),
    .pos(h_pos), .idx(h_idx), .active(h_act), .at_end(h_end)
  );

  rd_axis_seq #(.LEAD(V_LEAD)) u_vseq (
    .clk(clk), .rst_n(rst_sn), .step(v_step), .clear(load),
    .kept(kr), .blank(span_t'(cfg_q.vblank)),
    .pos(v_pos), .idx(v_idx), .active(v_act), .at_end(v_end)
  );

  // address generation
  span_t col_base, row_base, c_off, r_off, c_lin, r_lin;
  logic  live;

  always_comb begin
    live      = ~load_pend_q;
    pix_valid = h_act & v_act & live;
    col_base  = span_t'(cfg_q.col0 & ~COL_W'(1));
    row_base  = span_t'(cfg_q.row0);
    c_off     = unit_offset(h_idx, cfg_q.sub_c);
    r_off     = unit_offset(v_idx, cfg_q.sub_r);
    c_lin     = col_base + (cfg_q.mir_h ? (span_t'(cfg_q.cols) - span_t'(1) - c_off) : c_off);
    r_lin     = row_base + (cfg_q.mir_v ? (span_t'(cfg_q.rows) - span_t'(1) - r_off) : r_off);
    col_addr  = pix_valid ? c_lin[COL_W-1:0] : '0;
    row_addr  = pix_valid ? r_lin[ROW_W-1:0] : '0;
  end

  rd_sync_gen u_hsync (
    .pos(h_pos), .start(span_t'(cfg_q.hs_beg)), .width(span_t'(cfg_q.hs_wid)),
    .dv_mode(cfg_q.hs_dv), .dv_span(h_act & v_act), .pol(cfg_q.hs_pol),
    .gate(live), .sync_o(hsync)
  );

  rd_sync_gen u_vsync (
    .pos(v_pos), .start(span_t'(cfg_q.vs_beg)), .width(span_t'(cfg_q.vs_wid)),
    .dv_mode(cfg_q.vs_dv), .dv_span(v_act), .pol(cfg_q.vs_pol),
    .gate(live), .sync_o(vsync)
  );

  // R11: a strobed column lies inside the captured window
  assert_col_in_window_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    pix_valid |-> (c_lin >= col_base && c_lin < col_base + span_t'(cfg_q.cols)));

  // R8: a strobed row lies inside the captured window in either order
  assert_row_in_window_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    pix_valid |-> (r_lin >= row_base && r_lin < row_base + span_t'(cfg_q.rows)));

  // R3: an unmirrored line begins on an even column
  assert_even_start_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (pix_valid && !cfg_q.mir_h && h_idx == '0) |-> !col_addr[0]);

  // R9: a held line end keeps the line position
  assert_hold_line_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (dclk_en && h_end && !hold_n && live) |=> $stable(h_pos));

  // R6: data-valid horizontal sync tracks the pixel strobe
  assert_hs_valid_mode_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (live && cfg_q.hs_dv) |-> ((hsync ^ cfg_q.hs_pol) == pix_valid));
endmodule

// File: tb/tb_img_readout_timer.sv
module tb_img_readout_timer;
  import rd_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic [CODE_W-1:0] div_sel;
  logic [ROW_W-1:0]  win_row0, win_rows;
  logic [COL_W-1:0]  win_col0, win_cols;
  logic [1:0]        sub_row, sub_col;
  logic              mirror_h, mirror_v;
  logic [HB_W-1:0]   hblank;
  logic [VB_W-1:0]   vblank;
  logic [SW_W-1:0]   hs_width, vs_width;
  logic [SP_W-1:0]   hs_start, vs_start;
  logic              hs_pol, vs_pol, hs_valid_mode, vs_valid_mode, hold_n;
  logic              dclk_en, hsync, vsync, pix_valid;
  logic [ROW_W-1:0]  row_addr;
  logic [COL_W-1:0]  col_addr;

  img_readout_timer dut (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
    .win_row0(win_row0), .win_col0(win_col0), .win_rows(win_rows), .win_cols(win_cols),
    .sub_row(sub_row), .sub_col(sub_col), .mirror_h(mirror_h), .mirror_v(mirror_v),
    .hblank(hblank), .vblank(vblank), .hs_width(hs_width), .vs_width(vs_width),
    .hs_start(hs_start), .vs_start(vs_start), .hs_pol(hs_pol), .vs_pol(vs_pol),
    .hs_valid_mode(hs_valid_mode), .vs_valid_mode(vs_valid_mode), .hold_n(hold_n),
    .dclk_en(dclk_en), .row_addr(row_addr), .col_addr(col_addr),
    .hsync(hsync), .vsync(vsync), .pix_valid(pix_valid)
  );

  localparam int HL = 42;
  localparam int VL = 2;

  typedef struct packed {
    int row0; int col0; int rows; int cols; int sub_r; int sub_c;
    int mir_h; int mir_v; int hblank; int vblank; int hs_wid; int vs_wid;
    int hs_beg; int vs_beg; int hs_pol; int vs_pol; int hs_dv; int vs_dv; int div;
  } tcfg_t;

  typedef struct packed { int hs; int vs; int pv; int row; int col; } obs_t;

  int checks = 0;
  int errors = 0;

  function automatic int kept_n(input int len, input int code);
    int n = 0;
    for (int i = 0; i < len; i++) if ((i % (2 * (code + 1))) < 2) n++;
    return n;
  endfunction

  function automatic int src_off(input int idx, input int code);
    int c = 0;
    int found = -1;
    for (int i = 0; i < 4096; i++) begin
      if (found < 0 && (i % (2 * (code + 1))) < 2) begin
        if (c == idx) found = i;
        c++;
      end
    end
    return found;
  endfunction

  function automatic obs_t expect_at(input tcfg_t c, input int v, input int h);
    obs_t o;
    int kc = kept_n(c.cols, c.sub_c);
    int kr = kept_n(c.rows, c.sub_r);
    int ha = (h >= HL && h < HL + kc) ? 1 : 0;
    int va = (v >= VL && v < VL + kr) ? 1 : 0;
    int raw;
    o.pv = ha & va;
    o.col = 0;
    o.row = 0;
    if (o.pv == 1) begin
      o.col = ((c.col0 / 2) * 2 + (c.mir_h != 0 ? c.cols - 1 - src_off(h - HL, c.sub_c)
                                                : src_off(h - HL, c.sub_c))) % 1024;
      o.row = (c.row0 + (c.mir_v != 0 ? c.rows - 1 - src_off(v - VL, c.sub_r)
                                      : src_off(v - VL, c.sub_r))) % 512;
    end
    raw  = (c.hs_dv != 0) ? (ha & va) : ((h >= c.hs_beg && h < c.hs_beg + c.hs_wid) ? 1 : 0);
    o.hs = raw ^ c.hs_pol;
    raw  = (c.vs_dv != 0) ? va : ((v >= c.vs_beg && v < c.vs_beg + c.vs_wid) ? 1 : 0);
    o.vs = raw ^ c.vs_pol;
    return o;
  endfunction

  function automatic obs_t now_obs();
    obs_t o;
    o.hs = int'(hsync); o.vs = int'(vsync); o.pv = int'(pix_valid);
    o.row = int'(row_addr); o.col = int'(col_addr);
    return o;
  endfunction

  task automatic check_obs(input string req, input obs_t e, input int p);
    obs_t a = now_obs();
    checks++;
    if (a != e) begin
      errors++;
      $display("FAIL %s sample %0d: got hs=%0d vs=%0d pv=%0d row=%0d col=%0d expected hs=%0d vs=%0d pv=%0d row=%0d col=%0d",
               req, p, a.hs, a.vs, a.pv, a.row, a.col, e.hs, e.vs, e.pv, e.row, e.col);
    end
  endtask

  task automatic apply(input tcfg_t c);
    win_row0 = ROW_W'(c.row0); win_col0 = COL_W'(c.col0);
    win_rows = ROW_W'(c.rows); win_cols = COL_W'(c.cols);
    sub_row = 2'(c.sub_r); sub_col = 2'(c.sub_c);
    mirror_h = 1'(c.mir_h); mirror_v = 1'(c.mir_v);
    hblank = HB_W'(c.hblank); vblank = VB_W'(c.vblank);
    hs_width = SW_W'(c.hs_wid); vs_width = SW_W'(c.vs_wid);
    hs_start = SP_W'(c.hs_beg); vs_start = SP_W'(c.vs_beg);
    hs_pol = 1'(c.hs_pol); vs_pol = 1'(c.vs_pol);
    hs_valid_mode = 1'(c.hs_dv); vs_valid_mode = 1'(c.vs_dv);
    div_sel = CODE_W'(c.div);
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (dclk_en !== 1'b1);
  endtask

  // R12: reset holds outputs idle, the capture tick is idle too
  task automatic start(input tcfg_t c, input logic hold_v);
    obs_t idle = '0;
    rst_n = 1'b0;
    apply(c);
    hold_n = hold_v;
    repeat (3) @(negedge clk);
    check_obs("R12 in reset", idle, -1);
    rst_n = 1'b1;
    wait_tick();
    check_obs("R12 capture tick", idle, -1);
  endtask

  task automatic run_seq(input string req, input tcfg_t ca, input tcfg_t cb,
                         input int n, input int sw);
    tcfg_t cur = ca;
    int h = 0;
    int v = 0;
    for (int p = 0; p < n; p++) begin
      wait_tick();
      check_obs(req, expect_at(cur, v, h), p);
      if (p == sw) apply(cb);
      h++;
      if (h == kept_n(cur.cols, cur.sub_c) + cur.hblank) begin
        h = 0;
        v++;
        if (v == kept_n(cur.rows, cur.sub_r) + cur.vblank) begin
          v = 0;
          cur = cb;
        end
      end
    end
  endtask

  tcfg_t cfg_a, cfg_b, cfg_c, cfg_d;

  task automatic t_divider();
    for (int code = 0; code < 4; code++) begin
      tcfg_t c = cfg_a;
      c.div = code;
      start(c, 1'b1);
      for (int k = 0; k < 2; k++) begin
        int n = 0;
        do begin @(negedge clk); n++; end while (dclk_en !== 1'b1);
        checks++;
        if (n != (1 << code)) begin
          errors++;
          $display("FAIL R1 code %0d: period %0d expected %0d", code, n, 1 << code);
        end
      end
    end
  endtask

  task automatic t_defaults();
    start(cfg_d, 1'b1);
    run_seq("R2 R4 R11 default geometry", cfg_d, cfg_d, 1500, -1);
  endtask

  task automatic t_subsample();
    start(cfg_a, 1'b1);
    run_seq("R3 R7 R2 thinned window", cfg_a, cfg_a, 770, -1);
  endtask

  task automatic t_mirror();
    start(cfg_b, 1'b1);
    run_seq("R8 R5 mirrored and delayed syncs", cfg_b, cfg_b, 1130, -1);
  endtask

  task automatic t_valid_mode();
    start(cfg_c, 1'b1);
    run_seq("R6 data-valid syncs", cfg_c, cfg_c, 770, -1);
  endtask

  task automatic t_midframe();
    start(cfg_a, 1'b1);
    run_seq("R10 mid-frame rewrite", cfg_a, cfg_b, 385 + 1120, 100);
  endtask

  task automatic t_hold();
    int last = kept_n(cfg_a.cols, cfg_a.sub_c) + cfg_a.hblank - 1;
    start(cfg_a, 1'b0);
    for (int p = 0; p <= last; p++) begin
      wait_tick();
      check_obs("R9 line before hold", expect_at(cfg_a, 0, p), p);
    end
    for (int p = 0; p < 15; p++) begin
      wait_tick();
      check_obs("R9 line held", expect_at(cfg_a, 0, last), p);
    end
    hold_n = 1'b1;
    for (int p = 0; p < 3; p++) begin
      wait_tick();
      check_obs("R9 line after release", expect_at(cfg_a, 1, p), p);
    end
  endtask

  initial begin
    cfg_a = '{row0:10, col0:5, rows:12, cols:20, sub_r:2, sub_c:1, mir_h:0, mir_v:0,
              hblank:45, vblank:3, hs_wid:6, vs_wid:1, hs_beg:0, vs_beg:0,
              hs_pol:0, vs_pol:0, hs_dv:0, vs_dv:0, div:1};
    cfg_b = '{row0:3, col0:8, rows:16, cols:24, sub_r:0, sub_c:3, mir_h:1, mir_v:1,
              hblank:50, vblank:4, hs_wid:5, vs_wid:2, hs_beg:7, vs_beg:1,
              hs_pol:1, vs_pol:1, hs_dv:0, vs_dv:0, div:0};
    cfg_c = cfg_a;
    cfg_c.hs_dv = 1; cfg_c.vs_dv = 1; cfg_c.vs_pol = 1; cfg_c.div = 2;
    cfg_d = '{row0:14, col0:14, rows:288, cols:352, sub_r:0, sub_c:0, mir_h:0, mir_v:0,
              hblank:148, vblank:111, hs_wid:32, vs_wid:1, hs_beg:0, vs_beg:0,
              hs_pol:0, vs_pol:0, hs_dv:0, vs_dv:0, div:0};
    rst_n = 1'b0;
    hold_n = 1'b1;
    apply(cfg_a);
    t_divider();
    t_defaults();
    t_subsample();
    t_mirror();
    t_valid_mode();
    t_midframe();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule